// File: doc/BRIEF.md
# Option ROM Window with Shadow RAM

This block serves host byte reads and writes that fall inside a host adapter's expansion ROM window. The host address is reduced by a mask equal to the window size minus one, so any address bits above the window alias onto the same bytes. The window size comes from the ROM image length, rounded up to 8, 16, 32 or 64 KB. The ROM itself sits outside the block. The block drives a ROM address made of a bank bit and a 14-bit offset, and it takes the ROM byte back combinationally. Two 16 KB banks exist: bank 0 holds the main boot code and bank 1 holds the setup utility.

The top 128 bytes of the selected bank (offsets 0x3F80 to 0x3FFF) are overlaid by a small scratch RAM. The same storage is shared by both banks. While the scratch area is disabled, it reads as blank ROM (0xFF) and ignores host writes. While it is enabled, it reads and writes like ordinary memory.

A one-byte command port switches banks and controls the scratch area. Each accepted command returns a status byte one cycle later. The clear commands zero the area one byte per cycle, and a busy flag blocks further commands until the clear is done.

Top module: `oprom_window`

## Requirements
- R1: After reset, bank 0 is selected, the scratch area is disabled, `cmd_busy` and `sts_valid` are low, and `host_rdata` is 0x00.
- R2: The window size is the image length rounded up to 8192, 16384, 32768 or 65536 bytes. The host address is ANDed with the window size minus one, so higher address bits alias.
- R3: `host_rdata` is registered and is valid in the cycle after `host_rd`. For offsets outside the scratch area, it returns `rom_data` for `rom_addr`, where `rom_addr[14]` is the selected bank and `rom_addr[13:0]` is the masked offset.
- R4: The scratch area covers masked offsets 0x3F80 to 0x3FFF. While the area is enabled and not busy, a write there stores the byte, and a later read returns it.
- R5: A host write at any masked offset outside 0x3F80 to 0x3FFF has no effect, and a read there returns the ROM byte.
- R6: While the scratch area is disabled, reads in it return 0xFF and writes to it are ignored.
- R7: Command 0x27 selects bank 1 and command 0x26 selects bank 0. Both return status 0x00. The scratch contents are shared by both banks.
- R8: Command 0x00 disables the scratch area at once and returns status 0x04.
- R9: Command 0x03 enables the area and zeroes all 128 bytes. Command 0x02 zeroes all 128 bytes and leaves the enable state unchanged. Both return status 0x04. `cmd_busy` is high for exactly 128 cycles, starting in the cycle after the command is accepted.
- R10: While `cmd_busy` is high, commands are ignored and give no status, and host writes to the scratch area are ignored.
- R11: Any other command code returns status 0xFF and changes no state.
- R12: `sts_valid` pulses for exactly one cycle, in the cycle after a command is accepted, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | HADDR_W | Host byte address |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wr | input | 1 | Write strobe, one cycle |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Registered read byte |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command byte |
| cmd_busy | output | 1 | Scratch clear in progress; commands blocked |
| sts_valid | output | 1 | Status byte valid (one-cycle pulse) |
| sts_code | output | 8 | Status byte |
| rom_addr | output | 15 | External ROM address: bank bit and offset |
| rom_data | input | 8 | External ROM byte for `rom_addr` |

## Verification
The bench builds the block with an image length of 12000 bytes, so the window rounds up to 16 KB and the scratch area can be reached. It also uses a 20-bit host address, which leaves six alias bits above the window. Host addresses with those upper bits set show that masking folds them away, both for ROM reads and for scratch writes. The bench attaches a ROM model whose bytes depend on the bank bit, so a bank switch shows up directly in the read data.

// File: rtl/oprom_pkg.sv
// Package: shared constants and helpers for the option ROM window.
// Assumes byte-wide host accesses and one-byte command codes.
package oprom_pkg;

    localparam logic [7:0] CMD_BANK_SETUP = 8'h27;
    localparam logic [7:0] CMD_BANK_BOOT  = 8'h26;
    localparam logic [7:0] CMD_SCR_OFF    = 8'h00;
    localparam logic [7:0] CMD_SCR_CLEAR  = 8'h02;
    localparam logic [7:0] CMD_SCR_ON     = 8'h03;

    localparam logic [7:0] STS_BANK_OK = 8'h00;
    localparam logic [7:0] STS_SCR_OK  = 8'h04;
    localparam logic [7:0] STS_UNKNOWN = 8'hFF;
    localparam logic [7:0] BLANK_BYTE  = 8'hFF;

    // Round an image length up to the nearest supported window size.
    function automatic int win_bytes(input int img_bytes);
        if (img_bytes <= 8192)       return 8192;
        else if (img_bytes <= 16384) return 16384;
        else if (img_bytes <= 32768) return 32768;
        else                         return 65536;
    endfunction

    // True for the codes that act on the scratch area.
    function automatic logic is_scr_cmd(input logic [7:0] code);
        return (code == CMD_SCR_OFF) || (code == CMD_SCR_CLEAR) || (code == CMD_SCR_ON);
    endfunction

    // True for the codes that switch banks.
    function automatic logic is_bank_cmd(input logic [7:0] code);
        return (code == CMD_BANK_SETUP) || (code == CMD_BANK_BOOT);
    endfunction

endpackage

// File: rtl/oprom_addr_map.sv
// Address map: masks the host address to the window, forms the external
// ROM address and flags hits on the scratch overlay at the top of the bank.
// Assumes HADDR_W covers the largest window. Offsets past the bank alias
// into the bank for ROM reads but never hit the scratch area.
module oprom_addr_map #(
    parameter int HADDR_W    = 20,
    parameter int WIN_BYTES  = 16384,
    parameter int BANK_BYTES = 16384,
    parameter int SCR_BYTES  = 128
) (
    input  logic [HADDR_W-1:0]            host_addr,
    input  logic                          bank,
    output logic [$clog2(BANK_BYTES):0]   rom_addr,
    output logic                          scr_hit,
    output logic [$clog2(SCR_BYTES)-1:0]  scr_idx
);
    localparam int OFF_W    = $clog2(BANK_BYTES);
    localparam int SCR_W    = $clog2(SCR_BYTES);
    localparam int SCR_BASE = BANK_BYTES - SCR_BYTES;
    localparam logic [HADDR_W-1:0] WIN_MASK = HADDR_W'(WIN_BYTES - 1);

    logic [HADDR_W-1:0] masked;

    // Fold the host address onto the window.
    always_comb masked = host_addr & WIN_MASK;

    assign rom_addr = {bank, masked[OFF_W-1:0]};
    assign scr_idx  = masked[SCR_W-1:0];

    // A window too small to reach the overlay never hits it.
    if (SCR_BASE >= WIN_BYTES) begin : g_no_scr
        assign scr_hit = 1'b0;
    end else begin : g_scr
        assign scr_hit = (masked >= HADDR_W'(SCR_BASE)) &&
                         (masked <  HADDR_W'(BANK_BYTES));
    end

endmodule

// File: rtl/oprom_scratch_ram.sv
// Scratch RAM: byte store for the overlay with one host write port, one
// clear port driven by the controller, and a combinational read port.
// Contents are not reset: the controller keeps the area disabled (blank)
// until an enable command has zeroed it.
module oprom_scratch_ram #(
    parameter int DEPTH = 128,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] mem [DEPTH];

    // Store one byte per cycle; a clear step takes the port over.
    always_ff @(posedge clk) begin
        if (clr_en)
            mem[clr_idx] <= 8'h00;
        else if (wr_en)
            mem[wr_idx] <= wr_data;
    end

    // Read the selected byte combinationally.
    assign rd_data = mem[rd_idx];

    // R10
    clr_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> !wr_en)
        else $error("host write reached scratch RAM during a clear");

endmodule

// File: rtl/oprom_cmd_ctrl.sv
// Command controller: decodes command bytes, holds the bank select and
// the scratch enable, runs the byte-per-cycle clear and returns status.
// Assumes cmd_valid is a one-cycle strobe; commands seen while busy are dropped.
module oprom_cmd_ctrl
    import oprom_pkg::*;
#(
    parameter int SCR_BYTES = 128,
    parameter int IDX_W     = $clog2(SCR_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_code,
    output logic             bank,
    output logic             scr_en,
    output logic             busy,
    output logic [IDX_W-1:0] clr_idx,
    output logic             sts_valid,
    output logic [7:0]       sts_code
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SCR_BYTES - 1);

    logic accept;

    // A command is taken only when no clear is running.
    assign accept = cmd_valid && !busy;

    // Apply commands, step the clear and produce the status pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank      <= 1'b0;
            scr_en    <= 1'b0;
            busy      <= 1'b0;
            clr_idx   <= '0;
            sts_valid <= 1'b0;
            sts_code  <= 8'h00;
        end else begin
            sts_valid <= 1'b0;
            if (busy) begin
                clr_idx <= clr_idx + 1'b1;
                if (clr_idx == LAST_IDX)
                    busy <= 1'b0;
            end
            if (accept) begin
                sts_valid <= 1'b1;
                case (cmd_code)
                    CMD_BANK_SETUP: begin bank <= 1'b1; sts_code <= STS_BANK_OK; end
                    CMD_BANK_BOOT:  begin bank <= 1'b0; sts_code <= STS_BANK_OK; end
                    CMD_SCR_OFF:    begin scr_en <= 1'b0; sts_code <= STS_SCR_OK; end
                    CMD_SCR_CLEAR: begin
                        busy     <= 1'b1;
                        clr_idx  <= '0;
                        sts_code <= STS_SCR_OK;
                    end
                    CMD_SCR_ON: begin
                        scr_en   <= 1'b1;
                        busy     <= 1'b1;
                        clr_idx  <= '0;
                        sts_code <= STS_SCR_OK;
                    end
                    default:        sts_code <= STS_UNKNOWN;
                endcase
            end
        end
    end

    // R8 R9
    sts_scratch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && is_scr_cmd(cmd_code)) |=> (sts_valid && sts_code == STS_SCR_OK))
        else $error("scratch command status wrong");

    // R7
    sts_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && is_bank_cmd(cmd_code)) |=> (sts_valid && sts_code == STS_BANK_OK))
        else $error("bank command status wrong");

    // R10
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> !sts_valid)
        else $error("command accepted while busy");

    // R7 R11
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && !busy && is_bank_cmd(cmd_code)) |=> $stable(bank))
        else $error("bank changed without a bank command");

endmodule

// File: rtl/oprom_window.sv
// Option ROM window top: joins the address map, command controller and
// scratch RAM, and registers the read byte (ROM, scratch or blank).
// Assumes one host access per cycle and an external ROM whose data
// follows rom_addr combinationally within the cycle.
module oprom_window
    import oprom_pkg::*;
#(
    parameter int HADDR_W     = 20,
    parameter int IMAGE_BYTES = 16384,
    parameter int BANK_BYTES  = 16384,
    parameter int SCR_BYTES   = 128
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [HADDR_W-1:0]          host_addr,
    input  logic                        host_rd,
    input  logic                        host_wr,
    input  logic [7:0]                  host_wdata,
    output logic [7:0]                  host_rdata,
    input  logic                        cmd_valid,
    input  logic [7:0]                  cmd_code,
    output logic                        cmd_busy,
    output logic                        sts_valid,
    output logic [7:0]                  sts_code,
    output logic [$clog2(BANK_BYTES):0] rom_addr,
    input  logic [7:0]                  rom_data
);
    localparam int WIN_BYTES = win_bytes(IMAGE_BYTES);
    localparam int SCR_W     = $clog2(SCR_BYTES);

    logic             bank;
    logic             scr_en;
    logic             scr_hit;
    logic [SCR_W-1:0] scr_idx;
    logic [SCR_W-1:0] clr_idx;
    logic [7:0]       scr_rdata;
    logic             scr_we;

    oprom_addr_map #(
        .HADDR_W(HADDR_W), .WIN_BYTES(WIN_BYTES),
        .BANK_BYTES(BANK_BYTES), .SCR_BYTES(SCR_BYTES)
    ) u_map (
        .host_addr(host_addr), .bank(bank), .rom_addr(rom_addr),
        .scr_hit(scr_hit), .scr_idx(scr_idx)
    );

    oprom_cmd_ctrl #(.SCR_BYTES(SCR_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .bank(bank), .scr_en(scr_en), .busy(cmd_busy), .clr_idx(clr_idx),
        .sts_valid(sts_valid), .sts_code(sts_code)
    );

    // Host writes land only in an enabled, idle scratch area.
    assign scr_we = host_wr && scr_hit && scr_en && !cmd_busy;

    oprom_scratch_ram #(.DEPTH(SCR_BYTES)) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(scr_we), .wr_idx(scr_idx),
        .wr_data(host_wdata), .clr_en(cmd_busy), .clr_idx(clr_idx),
        .rd_idx(scr_idx), .rd_data(scr_rdata)
    );

    // Register the read byte from ROM, scratch or blank fill.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata <= 8'h00;
        else if (host_rd) begin
            if (!scr_hit)
                host_rdata <= rom_data;
            else if (scr_en)
                host_rdata <= scr_rdata;
            else
                host_rdata <= BLANK_BYTE;
        end
    end

    // R6
    rd_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && scr_hit && !scr_en) |=> (host_rdata == BLANK_BYTE))
        else $error("disabled scratch read not blank");

    // R3 R5
    rd_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !scr_hit) |=> (host_rdata == $past(rom_data)))
        else $error("ROM read data mismatch");

endmodule

// File: tb/oprom_window_bench.sv
// Scoreboard bench: driver tasks queue expected read bytes and status
// bytes; a monitor pops and compares them as the design produces them.
module oprom_window_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] host_addr = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic        cmd_busy;
    logic        sts_valid;
    logic [7:0]  sts_code;
    logic [14:0] rom_addr;
    logic [7:0]  rom_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] rd_exp[$];
    string      rd_tag[$];
    logic [7:0] st_exp[$];
    string      st_tag[$];

    always #2 clk = ~clk;

    // ROM model: bytes differ between banks.
    function automatic logic [7:0] rom_byte(input logic bnk, input logic [13:0] off);
        return off[7:0] ^ {1'b0, off[13:7]} ^ (bnk ? 8'hC3 : 8'h00);
    endfunction

    assign rom_data = rom_byte(rom_addr[14], rom_addr[13:0]);

    oprom_window #(.HADDR_W(20), .IMAGE_BYTES(12000)) u_oprom_window (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_busy(cmd_busy),
        .sts_valid(sts_valid), .sts_code(sts_code), .rom_addr(rom_addr),
        .rom_data(rom_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Window is 16 KB (R2), so the expected ROM offset is the low 14 bits.
    function automatic logic [7:0] rom_at(input logic bnk, input logic [19:0] a);
        return rom_byte(bnk, a[13:0]);
    endfunction

    task automatic rd(input logic [19:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        rd_exp.push_back(exp); rd_tag.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wr(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] code, input bit has_sts,
                       input logic [7:0] exp, input string tag);
        @(negedge clk);
        cmd_code = code; cmd_valid = 1'b1;
        if (has_sts) begin st_exp.push_back(exp); st_tag.push_back(tag); end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (cmd_busy) begin n++; @(negedge clk); end
    endtask

    // Monitor: compare registered outputs just after each edge.
    initial begin
        forever begin
            logic fired;
            @(posedge clk);
            fired = host_rd;
            #1;
            if (fired && rst_n) begin
                if (rd_exp.size() == 0) chk("R3 unexpected read", host_rdata, 8'hxx);
                else chk(rd_tag.pop_front(), host_rdata, rd_exp.pop_front());
            end
            if (sts_valid) begin
                if (st_exp.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R12 unexpected status: got %h expected none", sts_code);
                end else chk(st_tag.pop_front(), sts_code, st_exp.pop_front());
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata", host_rdata, 8'h00);
        chk("R1 busy", {7'd0, cmd_busy}, 8'h00);
        chk("R1 sts_valid", {7'd0, sts_valid}, 8'h00);
        rd(20'hC0123, rom_at(1'b0, 20'hC0123), "R1 R2 R3 bank0 aliased read");
        rd(20'h03F80, 8'hFF, "R1 R6 scratch blank after reset");
        wr(20'h03F85, 8'h11);
        rd(20'h03F85, 8'hFF, "R6 write ignored while disabled");

        cmd(8'h03, 1'b1, 8'h04, "R9 enable status");
        wait_idle(n);
        chk("R9 busy length", 8'(n), 8'd128);
        rd(20'h03FC0, 8'h00, "R9 enable zeroes area");

        wr(20'h7BF80, 8'hA5);
        wr(20'h03FFF, 8'h3C);
        rd(20'h03F80, 8'hA5, "R4 R2 aliased scratch write");
        rd(20'hFFFFF, 8'h3C, "R4 R2 top byte");
        wr(20'h03F7F, 8'h99);
        rd(20'h03F7F, rom_at(1'b0, 20'h03F7F), "R5 write below area ignored");

        cmd(8'h27, 1'b1, 8'h00, "R7 select bank1 status");
        rd(20'h00123, rom_at(1'b1, 20'h00123), "R7 bank1 read");
        rd(20'h03F80, 8'hA5, "R7 scratch shared by banks");
        cmd(8'h00, 1'b1, 8'h04, "R8 disable status");
        rd(20'h03F80, 8'hFF, "R8 disabled reads blank");
        cmd(8'h26, 1'b1, 8'h00, "R7 select bank0 status");
        rd(20'h00123, rom_at(1'b0, 20'h00123), "R7 bank0 read");

        cmd(8'h03, 1'b1, 8'h04, "R9 enable status");
        wait_idle(n);
        wr(20'h03F90, 8'h77);
        rd(20'h03F90, 8'h77, "R4 store before clear");
        cmd(8'h02, 1'b1, 8'h04, "R9 clear status");
        wait_idle(n);
        chk("R9 clear busy length", 8'(n), 8'd128);
        rd(20'h03F90, 8'h00, "R9 clear zeroes and keeps enable");
        cmd(8'h00, 1'b1, 8'h04, "R8 disable status");
        cmd(8'h02, 1'b1, 8'h04, "R9 clear while disabled status");
        wait_idle(n);
        rd(20'h03F90, 8'hFF, "R9 clear keeps disabled");

        cmd(8'h03, 1'b1, 8'h04, "R10 enable status");
        cmd(8'h27, 1'b0, 8'h00, "R10 dropped");
        wr(20'h03FA0, 8'h5E);
        wait_idle(n);
        rd(20'h03FA0, 8'h00, "R10 write during busy ignored");
        rd(20'h00123, rom_at(1'b0, 20'h00123), "R10 bank command during busy ignored");

        cmd(8'h55, 1'b1, 8'hFF, "R11 unknown status");
        rd(20'h03FA0, 8'h00, "R11 scratch state unchanged");
        rd(20'h00456, rom_at(1'b0, 20'h00456), "R11 bank unchanged");

        repeat (4) @(negedge clk);
        chk("R12 status queue drained", 8'(st_exp.size()), 8'd0);
        chk("R3 read queue drained", 8'(rd_exp.size()), 8'd0);
        finish_up();
    end

endmodule